// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects a parameterised set of level-sensitive hardware interrupt lines, whose count is a multiple of 32, and steers them to a small group of CPUs. Each source has a mask bit, a software-pending bit and a per-CPU routing word. Any CPU can also raise an inter-processor interrupt on any set of CPUs. Each CPU has one interrupt-request output. Software on that CPU services it by reading a per-CPU event register. The read returns the next event and claims it in the same access.

All access goes through a 32-bit register port. Each request carries the index of the CPU that issues it, so per-CPU registers such as the event, acknowledge and identity registers act on the caller's own state. Only one access happens per cycle. A read is answered one cycle later with `rsp_valid` high for exactly one cycle. A write produces no response. The port has no back-pressure: every request is accepted in the cycle it is presented.

Register offsets (byte addresses): 0x0004 capacity, 0x2000 caller identity, 0x2004 event, 0x2008 inter-processor send, 0x200C inter-processor acknowledge, 0x2028 inter-processor unmask, 0x3000 + 4·n routing word of source n. Four bit banks start at 0x4000 (software set), 0x4080 (software clear), 0x4100 (mask set) and 0x4180 (mask clear). In each bank, source n sits in word n/32 at bit n mod 32.

Top module: `intc_mp_top`

## Requirements
- R1: A read of 0x0004 returns NUM_IRQ in bits 15:0 and zero above. A read of 0x2000 returns the index of the requesting CPU.
- R2: After reset, every source is masked (mask words read all ones), software-pending words and routing words read zero, no inter-processor interrupt is pending, and every `irq_o` bit is low.
- R3: In the four bit banks, a write sets (0x4000, 0x4100) or clears (0x4080, 0x4180) exactly the state bits where the written data is one. Reading either address of a pair returns the current state word: software-pending for 0x4000/0x4080, mask for 0x4100/0x4180.
- R4: Bit k of the routing word of source n makes source n visible to CPU k. A source routed to several CPUs is claimed by whichever reads first, and it is then not reported to the others.
- R5: A source is asserted when its input line or its software-pending bit is high. A masked source is never reported.
- R6: A read of 0x2004 by CPU k, with no inter-processor event active for k, returns type 1 in bits 31:16 and n in bits 15:0. Here n is the lowest-numbered asserted, unmasked source routed to k. The same read sets the mask bit of source n.
- R7: A read of 0x2004 with nothing to report returns 0 and changes no state.
- R8: A write to 0x2008 marks an inter-processor interrupt pending for each CPU k whose data bit k is one. A pending, unmasked inter-processor interrupt is reported ahead of any hardware source as type 4 with number 1, and that read sets the caller's inter-processor mask.
- R9: Writing 0x200C with bit 0 set clears the caller's pending inter-processor interrupt. Writing 0x2028 with bit 0 set clears the caller's inter-processor mask. Writes with bit 0 clear have no effect.
- R10: `irq_o[k]` is high exactly when a read of 0x2004 by CPU k would return a nonzero type.
- R11: `rsp_valid` is high in the cycle after a read request and only then. `rsp_rdata` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_IRQ | Level-sensitive hardware interrupt inputs |
| req_en | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The checker watches every read response on every cycle. It ties the type in an event response to the state of the caller's `irq_o` in the request cycle: zero exactly when the request was low. It also checks that only the legal types 0, 1 and 4 appear, that an inter-processor event always carries number 1, and that the capacity and identity registers answer correctly. Only the bench scenarios can show the claim side effects and the effect of each individual source. These cover the lowest-number ordering, the precedence of inter-processor events over hardware events, and the race between CPUs for a source routed to both.

// File: rtl/intc_mp_pkg.sv
package intc_mp_pkg;
  localparam logic [15:0] EVT_NONE = 16'd0;
  localparam logic [15:0] EVT_HW   = 16'd1;
  localparam logic [15:0] EVT_IPI  = 16'd4;
  localparam logic [15:0] IPI_CHAN = 16'd1;

  localparam logic [15:0] A_CAP     = 16'h0004;
  localparam logic [15:0] A_WHO     = 16'h2000;
  localparam logic [15:0] A_EVT     = 16'h2004;
  localparam logic [15:0] A_SEND    = 16'h2008;
  localparam logic [15:0] A_ACK     = 16'h200C;
  localparam logic [15:0] A_IPIUNM  = 16'h2028;
  localparam logic [15:0] A_ROUTE   = 16'h3000;
  localparam logic [8:0]  BANK_BASE = 9'h080; // 0x4000 >> 7

  typedef enum logic [1:0] {
    BK_SW_SET  = 2'd0,
    BK_SW_CLR  = 2'd1,
    BK_MSK_SET = 2'd2,
    BK_MSK_CLR = 2'd3
  } bank_op_e;
endpackage

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import intc_mp_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int IW      = $clog2(NUM_IRQ),
  parameter int WW      = (NUM_IRQ > 32) ? $clog2(NUM_IRQ / 32) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_IRQ-1:0]                lines,
  input  logic                              bank_we,
  input  bank_op_e                          bank_op,
  input  logic [WW-1:0]                     bank_word,
  input  logic [31:0]                       wdata,
  input  logic                              route_we,
  input  logic [IW-1:0]                     route_idx,
  input  logic                              claim_en,
  input  logic [IW-1:0]                     claim_idx,
  output logic [NUM_IRQ-1:0]                mask_q,
  output logic [NUM_IRQ-1:0]                sw_q,
  output logic [NUM_CPU-1:0]                route_rd,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]   elig
);
  localparam int NUM_WORDS = NUM_IRQ / 32;

  logic [NUM_IRQ-1:0][NUM_CPU-1:0] route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      sw_q    <= '0;
      route_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (bank_we && bank_word == WW'(w)) begin
          unique case (bank_op)
            BK_SW_SET:  sw_q[w*32 +: 32]   <= sw_q[w*32 +: 32] | wdata;
            BK_SW_CLR:  sw_q[w*32 +: 32]   <= sw_q[w*32 +: 32] & ~wdata;
            BK_MSK_SET: mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] | wdata;
            BK_MSK_CLR: mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] & ~wdata;
          endcase
        end
      end
      if (route_we) route_q[route_idx] <= wdata[NUM_CPU-1:0];
      if (claim_en) mask_q[claim_idx] <= 1'b1;
    end
  end

  assign route_rd = route_q[route_idx];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_elig
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_src
      assign elig[c][n] = (lines[n] | sw_q[n]) & ~mask_q[n] & route_q[n][c];
    end
  end
endmodule

// File: rtl/intc_ipi.sv
module intc_ipi #(
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_W-1:0]   cpu,
  input  logic               send_we,
  input  logic [NUM_CPU-1:0] send_bits,
  input  logic               ack_we,
  input  logic               unmask_we,
  input  logic               claim_en,
  output logic [NUM_CPU-1:0] active
);
  logic [NUM_CPU-1:0] pend_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      if (send_we)   pend_q      <= pend_q | send_bits;
      if (ack_we)    pend_q[cpu] <= 1'b0;
      if (unmask_we) mask_q[cpu] <= 1'b0;
      if (claim_en)  mask_q[cpu] <= 1'b1;
    end
  end

  assign active = pend_q & ~mask_q;
endmodule

// File: rtl/intc_mp_top.sv
module intc_mp_top
  import intc_mp_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               req_en,
  input  logic               req_we,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [15:0]        req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam int IW        = $clog2(NUM_IRQ);
  localparam int NUM_WORDS = NUM_IRQ / 32;
  localparam int WW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic rd, wr;
  assign rd = req_en & ~req_we;
  assign wr = req_en & req_we;

  // Address decode
  logic [15:0] route_off;
  logic        route_hit, bank_hit;
  logic [8:0]  bank_grp;
  logic [4:0]  word_raw;
  assign route_off = req_addr - A_ROUTE;
  assign route_hit = (req_addr >= A_ROUTE) && (32'(route_off[15:2]) < NUM_IRQ)
                     && (req_addr[1:0] == 2'b00);
  assign bank_grp  = req_addr[15:7] - BANK_BASE;
  assign word_raw  = req_addr[6:2];
  assign bank_hit  = (req_addr[15:7] >= BANK_BASE) && (bank_grp < 9'd4)
                     && (32'(word_raw) < NUM_WORDS) && (req_addr[1:0] == 2'b00);

  // Source state
  logic [NUM_IRQ-1:0]              mask_q, sw_q;
  logic [NUM_CPU-1:0]              route_rd;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] elig;
  logic                            hw_claim;
  logic [IW-1:0]                   hw_idx [NUM_CPU];
  logic [NUM_CPU-1:0]              hw_found;

  intc_src_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .IW(IW), .WW(WW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (irq_lines),
    .bank_we   (wr & bank_hit),
    .bank_op   (bank_op_e'(bank_grp[1:0])),
    .bank_word (word_raw[WW-1:0]),
    .wdata     (req_wdata),
    .route_we  (wr & route_hit),
    .route_idx (route_off[IW+1:2]),
    .claim_en  (hw_claim),
    .claim_idx (hw_idx[req_cpu]),
    .mask_q    (mask_q),
    .sw_q      (sw_q),
    .route_rd  (route_rd),
    .elig      (elig)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
    intc_lowest #(.W(NUM_IRQ), .IW(IW)) u_pick (
      .vec   (elig[c]),
      .found (hw_found[c]),
      .idx   (hw_idx[c])
    );
  end

  // Inter-processor signalling
  logic [NUM_CPU-1:0] ipi_active;
  logic               evt_rd, ipi_claim;
  assign evt_rd    = rd && (req_addr == A_EVT);
  assign ipi_claim = evt_rd && ipi_active[req_cpu];
  assign hw_claim  = evt_rd && !ipi_active[req_cpu] && hw_found[req_cpu];

  intc_ipi #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_ipi (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu       (req_cpu),
    .send_we   (wr && req_addr == A_SEND),
    .send_bits (req_wdata[NUM_CPU-1:0]),
    .ack_we    (wr && req_addr == A_ACK && req_wdata[0]),
    .unmask_we (wr && req_addr == A_IPIUNM && req_wdata[0]),
    .claim_en  (ipi_claim),
    .active    (ipi_active)
  );

  assign irq_o = ipi_active | hw_found;

  // Read data
  logic [31:0] rd_val, mask_word, sw_word;
  always_comb begin
    mask_word = '0;
    sw_word   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_raw == 5'(w)) begin
        mask_word = mask_q[w*32 +: 32];
        sw_word   = sw_q[w*32 +: 32];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (req_addr == A_CAP)            rd_val = 32'(NUM_IRQ) & 32'h0000_FFFF;
    else if (req_addr == A_WHO)       rd_val = 32'(req_cpu);
    else if (req_addr == A_EVT) begin
      if (ipi_active[req_cpu])        rd_val = {EVT_IPI, IPI_CHAN};
      else if (hw_found[req_cpu])     rd_val = {EVT_HW, 16'(hw_idx[req_cpu])};
    end
    else if (route_hit)               rd_val = 32'(route_rd);
    else if (bank_hit)                rd_val = bank_grp[1] ? mask_word : sw_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/intc_mp_checker.sv
module intc_mp_checker #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_en,
  input logic               req_we,
  input logic [CPU_W-1:0]   req_cpu,
  input logic [15:0]        req_addr,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic [NUM_CPU-1:0] irq_o
);
  logic was_rd, was_evt, was_cap, was_who, was_irq;
  logic [CPU_W-1:0] was_cpu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_rd <= 1'b0; was_evt <= 1'b0; was_cap <= 1'b0;
      was_who <= 1'b0; was_irq <= 1'b0; was_cpu <= '0;
    end else begin
      was_rd  <= req_en && !req_we;
      was_evt <= req_en && !req_we && req_addr == 16'h2004;
      was_cap <= req_en && !req_we && req_addr == 16'h0004;
      was_who <= req_en && !req_we && req_addr == 16'h2000;
      was_irq <= irq_o[req_cpu];
      was_cpu <= req_cpu;
    end
  end

  // R11: response strobe follows each read by one cycle
  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == was_rd);

  // R10: an event read with the request low yields nothing
  assert_quiet_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (was_evt && !was_irq) |-> rsp_rdata == 32'd0);

  // R10: an event read with the request high yields an event
  assert_busy_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (was_evt && was_irq) |-> rsp_rdata[31:16] != 16'd0);

  // R6 / R8: only legal types, and an inter-processor event carries number 1
  assert_event_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    was_evt |-> (rsp_rdata[31:16] == 16'd0 || rsp_rdata[31:16] == 16'd1 ||
                 rsp_rdata[31:16] == 16'd4));
  assert_ipi_number_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (was_evt && rsp_rdata[31:16] == 16'd4) |-> rsp_rdata[15:0] == 16'd1);

  // R6: a hardware event names an existing source
  assert_hw_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (was_evt && rsp_rdata[31:16] == 16'd1) |-> 32'(rsp_rdata[15:0]) < NUM_IRQ);

  // R1: capacity and identity registers
  assert_capacity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    was_cap |-> rsp_rdata == 32'(NUM_IRQ));
  assert_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    was_who |-> rsp_rdata == 32'(was_cpu));
endmodule

bind intc_mp_top intc_mp_checker #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_en    (req_en),
  .req_we    (req_we),
  .req_cpu   (req_cpu),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o)
);

// File: tb/intc_mp_top_tb_top.sv
module intc_mp_top_tb_top;
  localparam int NI = 64;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NI-1:0] irq_lines = '0;
  logic        req_en = 1'b0, req_we = 1'b0;
  logic [0:0]  req_cpu = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intc_mp_top #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .req_en(req_en),
    .req_we(req_we), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_en = 1; req_we = 1; req_cpu = 1'(cpu); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_en = 0; req_we = 0;
  endtask

  task automatic rd(input int cpu, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_en = 1; req_we = 0; req_cpu = 1'(cpu); req_addr = a;
    @(negedge clk);
    req_en = 0;
    d = rsp_rdata;
  endtask

  function automatic logic [15:0] bank(input logic [15:0] base, input int n);
    return base + 16'((n / 32) * 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state and identity
    chk("R2 irq after reset", 32'(irq_o), 0);
    rd(0, 16'h0004, v); chk("R1 capacity", v, NI);
    chk("R11 rsp_valid after read", 32'(rsp_valid), 1);
    rd(1, 16'h2000, v); chk("R1 identity cpu1", v, 1);
    rd(0, 16'h2000, v); chk("R1 identity cpu0", v, 0);
    rd(0, 16'h2004, v); chk("R2 event empty", v, 0);
    for (int w = 0; w < NI / 32; w++) begin
      rd(0, 16'h4100 + 16'(w * 4), v); chk("R2 mask word", v, 32'hFFFF_FFFF);
      rd(0, 16'h4000 + 16'(w * 4), v); chk("R2 sw word", v, 0);
    end
    rd(0, 16'h3000 + 16'd4 * 16'd17, v); chk("R2 route word", v, 0);

    // Masked source stays silent
    wr(0, 16'h3000, 32'h1);
    chk("R11 rsp_valid low after write", 32'(rsp_valid), 0);
    @(negedge clk); irq_lines[0] = 1; #1;
    chk("R5 masked line silent", 32'(irq_o), 0);
    rd(0, 16'h2004, v); chk("R5 masked no event", v, 0);
    @(negedge clk); irq_lines[0] = 0;
    wr(0, 16'h3000, 32'h0);

    // Sweep every source, alternating target CPU
    for (int n = 0; n < NI; n++) begin
      int c = n % 2;
      wr(0, 16'h3000 + 16'(4 * n), 32'(1 << c));
      wr(0, bank(16'h4180, n), 32'(1) << (n % 32));
      @(negedge clk); irq_lines[n] = 1; #1;
      chk("R10 sweep irq", 32'(irq_o), 32'(1 << c));
      rd(1 - c, 16'h2004, v); chk("R4 sweep other cpu", v, 0);
      rd(c, 16'h2004, v); chk("R6 sweep claim", v, (32'd1 << 16) | 32'(n));
      chk("R6 sweep irq after claim", 32'(irq_o), 0);
      rd(c, bank(16'h4100, n), v); chk("R3 mask relatched", v, 32'hFFFF_FFFF);
      @(negedge clk); irq_lines[n] = 0;
      wr(0, 16'h3000 + 16'(4 * n), 32'h0);
    end

    // Lowest number first
    wr(0, 16'h3000 + 16'd20, 32'h1);   // source 5
    wr(0, 16'h3000 + 16'd160, 32'h1);  // source 40
    wr(0, 16'h4180, 32'h20);
    wr(0, 16'h4184, 32'h100);
    rd(0, 16'h4184, v); chk("R3 mask clr word1", v, 32'hFFFF_FEFF);
    @(negedge clk); irq_lines[5] = 1; irq_lines[40] = 1;
    rd(0, 16'h2004, v); chk("R6 lowest first", v, 32'h0001_0005);
    rd(0, 16'h2004, v); chk("R6 next source", v, 32'h0001_0028);
    rd(0, 16'h2004, v); chk("R7 drained", v, 0);
    @(negedge clk); irq_lines[5] = 0; irq_lines[40] = 0;

    // Software pending
    wr(0, 16'h3000 + 16'd28, 32'h2);   // source 7 to cpu1
    wr(1, 16'h4000, 32'h80);
    rd(1, 16'h4080, v); chk("R3 sw set readback", v, 32'h80);
    chk("R5 sw masked silent", 32'(irq_o), 0);
    wr(1, 16'h4180, 32'h80);
    chk("R5 sw raises irq", 32'(irq_o), 32'h2);
    rd(1, 16'h2004, v); chk("R5 sw event", v, 32'h0001_0007);
    wr(1, 16'h4080, 32'h80);
    rd(1, 16'h4000, v); chk("R3 sw clr readback", v, 0);
    wr(1, 16'h4180, 32'h80);
    chk("R5 sw cleared silent", 32'(irq_o), 0);
    wr(1, 16'h4100, 32'h80);
    rd(1, 16'h4100, v); chk("R3 mask set", v, 32'hFFFF_FFFF);

    // Shared routing: first reader wins
    wr(0, 16'h3000 + 16'd36, 32'h3);   // source 9 to both
    wr(0, 16'h4180, 32'h200);
    @(negedge clk); irq_lines[9] = 1; #1;
    chk("R4 both cpus raised", 32'(irq_o), 32'h3);
    rd(1, 16'h2004, v); chk("R4 cpu1 claims", v, 32'h0001_0009);
    rd(0, 16'h2004, v); chk("R4 cpu0 sees none", v, 0);
    @(negedge clk); irq_lines[9] = 0;

    // Inter-processor with hardware pending on cpu1
    wr(0, 16'h3000 + 16'd12, 32'h2);   // source 3 to cpu1
    wr(0, 16'h4180, 32'h8);
    @(negedge clk); irq_lines[3] = 1;
    wr(0, 16'h2008, 32'h2);
    rd(1, 16'h2004, v); chk("R8 ipi precedence", v, 32'h0004_0001);
    rd(1, 16'h2004, v); chk("R8 ipi masked then hw", v, 32'h0001_0003);
    rd(1, 16'h2004, v); chk("R7 cpu1 drained", v, 0);
    chk("R10 cpu1 quiet", 32'(irq_o), 0);
    @(negedge clk); irq_lines[3] = 0;
    wr(1, 16'h2028, 32'h2);
    chk("R9 unmask needs bit0", 32'(irq_o), 0);
    wr(1, 16'h2028, 32'h1);
    chk("R9 unmask re-raises pending", 32'(irq_o), 32'h2);
    wr(1, 16'h200C, 32'h2);
    chk("R9 ack needs bit0", 32'(irq_o), 32'h2);
    wr(1, 16'h200C, 32'h1);
    chk("R9 ack clears", 32'(irq_o), 0);
    wr(1, 16'h2008, 32'h3);
    chk("R8 broadcast", 32'(irq_o), 32'h3);
    rd(0, 16'h2004, v); chk("R8 cpu0 ipi", v, 32'h0004_0001);
    chk("R8 cpu1 still raised", 32'(irq_o), 32'h2);
    wr(0, 16'h200C, 32'h1);
    wr(1, 16'h200C, 32'h1);
    chk("R9 both acked", 32'(irq_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule